// File: doc/BRIEF.md
# Addressable Scan Cluster Grid

This block is a grid of scan clusters that are loaded by address rather than by shifting. Each cluster holds one state bit that stands for every scan cell in that cluster. The address splits into a row field and a column field. Each field drives its own one-hot decoder, and a cluster is selected only when its row line and its column line are both active. Every cluster has a reset polarity fixed at elaboration, given as one bit per cluster in a parameter vector.

Reset puts every cluster at its polarity value. In load mode a tester drives only the addresses of the clusters whose stimulus bit differs from that value. Each addressed cluster is forced to the complement of its polarity, and all other clusters keep their state. In function mode every cluster captures its own functional data input, as an ordinary flip-flop does.

Top module: `scan_cluster_grid`

## Requirements
- R1: While rst_ni is low, each cluster output state_o[i] equals bit i of RST_POL, at once and whatever the other inputs are. The reset is asynchronous and active-low.
- R2: With rst_ni high and test_ctrl_i = 1 (function mode), each state_o[i] takes func_d_i[i] at the next rising edge.
- R3: With rst_ni high and test_ctrl_i = 0 (load mode), the selected cluster i takes ~RST_POL[i] at the next rising edge.
- R4: In load mode, every cluster that is not selected keeps its state across the edge.
- R5: The address is addr_i[XW+YW-1:YW] = row x and addr_i[YW-1:0] = column y, with XW = ceil(log2 ROWS) and YW = ceil(log2 COLS). The selected cluster has index x*COLS + y, and at most one cluster is selected at a time.
- R6: An address whose row is ROWS or more, or whose column is COLS or more, selects no cluster, so in load mode every state holds.
- R7: Selecting a cluster that was already forced leaves it at ~RST_POL[i]. A repeated select does not toggle it back.
- R8: In function mode the address has no effect, and a cluster whose address is driven still captures func_d_i[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to the polarity values |
| test_ctrl_i | input | 1 | 1 = function capture, 0 = addressed load |
| addr_i | input | XW+YW | Cluster address, row field above column field |
| func_d_i | input | ROWS*COLS | Functional data, one bit per cluster |
| state_o | output | ROWS*COLS | Cluster states, index row*COLS+col |

## Verification
Load and capture results are due at the first rising edge after the inputs change. The bench drives at the falling edge and compares state_o 5 ns after the next rising edge, so each result is checked exactly one register stage after its stimulus. A reset value is due with no edge at all, so the bench samples it 2 ns after rst_ni falls and again after an edge while reset is still held. A scoreboard queue holds one expected state vector per driven cycle, computed from an independent reference of the grid, and the monitor pops one entry per edge.

// File: rtl/cras_pkg.sv
`timescale 1ns/1ps
package cras_pkg;

  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,
    MODE_FUNC  = 2'd1,
    MODE_LOAD  = 2'd2
  } grid_mode_e;

  function automatic int unsigned field_width(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/axis_onehot_dec.sv
`timescale 1ns/1ps
module axis_onehot_dec #(
  parameter int unsigned LINES = 4,
  parameter int unsigned W     = 2
) (
  input  logic [W-1:0]     code_i,
  output logic [LINES-1:0] lines_o
);

  // codes at or above LINES match no line
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines_o[i] = (code_i == W'(i));
  end

endmodule

// File: rtl/scan_cluster_cell.sv
`timescale 1ns/1ps
module scan_cluster_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic func_i,
  input  logic sel_i,
  input  logic d_i,
  output logic q_o
);

  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RST_VAL;
    else if (func_i) state_q <= d_i;
    else if (sel_i)  state_q <= ~RST_VAL;
  end

  assign q_o = state_q;

  p_reset_val_r1: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == RST_VAL);

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_i |=> q_o == $past(d_i));

  p_force_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!func_i && sel_i) |=> q_o == ~RST_VAL);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!func_i && !sel_i) |=> $stable(q_o));

endmodule

// File: rtl/scan_cluster_grid.sv
`timescale 1ns/1ps
module scan_cluster_grid
  import cras_pkg::*;
#(
  parameter int unsigned ROWS = 3,
  parameter int unsigned COLS = 4,
  parameter logic [ROWS*COLS-1:0] RST_POL = 12'h63A,
  localparam int unsigned XW = field_width(ROWS),
  localparam int unsigned YW = field_width(COLS),
  localparam int unsigned AW = XW + YW,
  localparam int unsigned N  = ROWS * COLS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          test_ctrl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  func_d_i,
  output logic [N-1:0]  state_o
);

  grid_mode_e       mode;
  logic [XW-1:0]    row_code;
  logic [YW-1:0]    col_code;
  logic [ROWS-1:0]  row_line;
  logic [COLS-1:0]  col_line;
  logic [N-1:0]     sel;
  logic             func_en;

  always_comb begin
    if (!rst_ni)          mode = MODE_RESET;
    else if (test_ctrl_i) mode = MODE_FUNC;
    else                  mode = MODE_LOAD;
  end

  assign func_en  = (mode == MODE_FUNC);
  assign row_code = addr_i[AW-1:YW];
  assign col_code = addr_i[YW-1:0];

  axis_onehot_dec #(.LINES(ROWS), .W(XW)) u_row_dec (
    .code_i  (row_code),
    .lines_o (row_line)
  );

  axis_onehot_dec #(.LINES(COLS), .W(YW)) u_col_dec (
    .code_i  (col_code),
    .lines_o (col_line)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      assign sel[IDX] = row_line[r] & col_line[c];

      scan_cluster_cell #(.RST_VAL(RST_POL[IDX])) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .func_i (func_en),
        .sel_i  (sel[IDX]),
        .d_i    (func_d_i[IDX]),
        .q_o    (state_o[IDX])
      );
    end
  end

  p_one_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel) <= 1);

  p_oob_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(row_code) >= ROWS || 32'(col_code) >= COLS) |-> sel == '0);

  p_func_ignores_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ctrl_i |=> state_o == $past(func_d_i));

endmodule

// File: tb/scan_cluster_grid_tb_top.sv
`timescale 1ns/1ps
module scan_cluster_grid_tb_top;

  localparam int unsigned ROWS = 3;
  localparam int unsigned COLS = 4;
  localparam int unsigned N    = ROWS * COLS;
  localparam int unsigned AW   = 4;
  localparam logic [N-1:0] POL = 12'h63A;

  typedef struct {
    logic [N-1:0] exp;
    string        req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          tc = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  fd = '0;
  logic [N-1:0]  st;

  logic [N-1:0]  model;
  item_t         sb_q[$];
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  scan_cluster_grid #(.ROWS(ROWS), .COLS(COLS), .RST_POL(POL)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .test_ctrl_i (tc),
    .addr_i      (addr),
    .func_d_i    (fd),
    .state_o     (st)
  );

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: one stimulus per cycle, expected next state pushed to the scoreboard
  task automatic step(input logic t, input logic [AW-1:0] a, input logic [N-1:0] d, input string req);
    item_t it;
    int unsigned x, y;
    @(negedge clk);
    tc = t; addr = a; fd = d;
    x = 32'(a[3:2]);
    y = 32'(a[1:0]);
    if (t) model = d;
    else if (x < ROWS && y < COLS) model[x*COLS+y] = ~POL[x*COLS+y];
    it.exp = model;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(st, it.exp, it.req);
      end
    end
  end

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model = POL;
    #1 rst_ni = 1'b0;
    #2 check(st, POL, "R1 async reset value");
    @(posedge clk); #5 check(st, POL, "R1 reset held across edge");
    @(negedge clk); tc = 1'b0; addr = 4'b1111; rst_ni = 1'b1;

    // load mode: addressed clusters go to the complement of their polarity (R3, R5)
    step(1'b0, 4'b0001, '0, "R3 load x0 y1");
    step(1'b0, 4'b0110, '0, "R5 load x1 y2 index 6");
    step(1'b0, 4'b1011, '0, "R5 load x2 y3 index 11");
    step(1'b0, 4'b0000, '0, "R3 load x0 y0");
    step(1'b0, 4'b0100, '1, "R3 load x1 y0 ignores func data");
    // repeated select stays forced (R7)
    step(1'b0, 4'b0110, '0, "R7 reselect index 6");
    step(1'b0, 4'b0110, '0, "R7 reselect index 6 again");
    // out of range rows select nothing (R6), state held (R4)
    step(1'b0, 4'b1100, '1, "R6 row 3 out of range");
    step(1'b0, 4'b1101, '0, "R6 row 3 col 1 out of range");
    step(1'b0, 4'b1111, '1, "R4 hold with no selection");
    // function mode capture, address irrelevant (R2, R8)
    step(1'b1, 4'b0010, 12'hA5C, "R2 capture pattern A");
    step(1'b1, 4'b0010, 12'h5A3, "R8 capture with driven address");
    step(1'b1, 4'b1000, 12'hFFF, "R2 capture all ones");
    step(1'b1, 4'b0111, 12'h000, "R2 capture all zeros");
    // back to load mode from all zeros
    step(1'b0, 4'b1001, '1, "R3 load x2 y1 from zeros");
    step(1'b0, 4'b0011, '1, "R3 load x0 y3");
    step(1'b0, 4'b1110, '0, "R4 hold after loads");

    // mid-run asynchronous reset with a select driven (R1)
    @(negedge clk);
    rst_ni = 1'b0; tc = 1'b0; addr = 4'b0001;
    #2 check(st, POL, "R1 mid-run async reset");
    @(posedge clk); #5 check(st, POL, "R1 reset overrides select");
    @(negedge clk); addr = 4'b1111; rst_ni = 1'b1;
    model = POL;
    step(1'b0, 4'b1010, '0, "R3 load x2 y2 after reset");
    step(1'b0, 4'b1111, '0, "R4 hold after reset");

    repeat (3) @(posedge clk);
    #6;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule